// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block serves the move-to and move-from special-purpose register operations of a small 32-bit processor core. Each operation names a register through a 32-bit base operand and a 16-bit immediate. The block combines the two, decodes the result into a group and a register number, and steers the access to local storage. That storage is the status register, three exception registers, a 64-bit multiply-accumulate register, and way 0 of a data and an instruction translation buffer. Three configuration registers and two translation-configuration registers are read-only constants.

The write port takes one write per cycle, and the new value is visible from the next cycle on. The read port is combinational from registered storage. Every read also carries the value the destination register held before. That value is handed back whenever the address does not select a backed register, so the core can write its result unconditionally. Some writes alter state that affects translation. For these the block raises same-cycle strobes that the translation logic uses to drop cached lookups.

Top module: `spr_access_unit`

## Requirements
- R1: The register address is the bitwise OR of the base operand and the zero-extended immediate, not their sum. Bits 15..11 of the address are the group and bits 10..0 are the register number. An address with any of bits 31..16 set selects nothing.
- R2: Reads at group 0 return parameter constants: register 0 gives `VERSION` (default 32'h1200_0001), register 1 gives `UNIT_PRESENT` (default 32'h0000_0619), register 2 gives `CPU_CFG` (default 32'h0000_0020), and registers 3 and 4 give log2(N) in bits 4..2 with all other bits zero. Writes to registers 0 through 4 change nothing.
- R3: Group 0 register 17 (status), register 32 (exception PC), register 48 (exception address) and register 64 (exception status) each store a written 32-bit value and read it back.
- R4: A write to the status register whose data differs from the stored value in bit 0, bit 5 or bit 6 raises `flushAll` in the cycle of the write. Any other write leaves it low.
- R5: A write to a match entry (group 1 or 2, register 512+i, i < N) raises `flushPage` in the cycle of the write. `flushPageAddr` is then the old entry with its low `PAGE_BITS` (default 13) bits cleared, and `flushPageInstr` is 0 for group 1 and 1 for group 2. The new value is stored at the clock edge.
- R6: Group 1 is the data buffer and group 2 the instruction buffer. Match entries at registers 512+i and translate entries at registers 640+i, for i < N (default 64), store and read back 32-bit values. Writes to translate entries raise no flush.
- R7: Group 5 register 1 reads and writes bits 31..0 of the 64-bit accumulator, and register 2 reads and writes bits 63..32. A write to one half leaves the other half unchanged.
- R8: A read of any register not named in R2, R3, R6 or R7 returns `rdPrev` unchanged. This includes registers 16 and 18 of group 0, buffer numbers from 512+N to 639, from 640+N to 767, and from 768 to 1535. A write to such a register changes no stored value and raises no flush.
- R9: Read data follows the read inputs in the same cycle. A read of the register being written in that cycle returns the old value, and the new value appears from the next cycle.
- R10: After reset the status register reads 32'h0000_0001. The exception registers, both accumulator halves and all buffer entries read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request valid this cycle |
| wrBase | input | 32 | Write base operand |
| wrImm | input | 16 | Write immediate |
| wrData | input | 32 | Write data |
| rdBase | input | 32 | Read base operand |
| rdImm | input | 16 | Read immediate |
| rdPrev | input | 32 | Prior destination value, returned for unbacked registers |
| rdData | output | 32 | Read result |
| flushAll | output | 1 | Full translation flush strobe |
| flushPage | output | 1 | Single-page translation flush strobe |
| flushPageInstr | output | 1 | Page flush targets the instruction buffer |
| flushPageAddr | output | 32 | Page address to flush |

## Verification
The properties take for granted that reset is applied before any access. They also assume the read inputs carry settled values in every cycle, because the read path is purely combinational. The stability check on the read result relies on the write port being idle in the previous cycle. The stimulus keeps to these assumptions: reset is held for several cycles first, and every input is driven only on the falling edge. Addresses are built as random splits of a target between the base and the immediate. They are biased toward backed registers, buffer index edges and status writes that do or do not toggle the mode bits, with a small share of addresses that have upper base bits set.

// File: rtl/spr_pkg.sv
package spr_pkg;

  localparam int TLB_IDX_W = 7;
  localparam logic [31:0] SR_MODE_MASK = 32'h0000_0061;
  localparam logic [31:0] SR_RESET = 32'h0000_0001;

  typedef enum logic [3:0] {
    SEL_PREV, SEL_VR, SEL_UPR, SEL_CPUCFG, SEL_DMMUCFG, SEL_IMMUCFG,
    SEL_SR, SEL_EPCR, SEL_EEAR, SEL_ESR, SEL_MACLO, SEL_MACHI, SEL_MR, SEL_TR
  } sprSel_e;

  typedef struct packed {
    sprSel_e sel;
    logic side;
    logic [TLB_IDX_W-1:0] idx;
  } sprTarget_t;

  typedef struct packed {
    logic sr;
    logic epcr;
    logic eear;
    logic esr;
    logic macLo;
    logic macHi;
    logic [1:0] mr;
    logic [1:0] tr;
    logic [TLB_IDX_W-1:0] idx;
  } sprWrStrobe_t;

endpackage

// File: rtl/spr_tlb_bank.sv
module spr_tlb_bank
  import spr_pkg::*;
#(
  parameter int N = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrMr,
  input  logic wrTr,
  input  logic [TLB_IDX_W-1:0] wrIdx,
  input  logic [31:0] wrData,
  input  logic [TLB_IDX_W-1:0] rdIdx,
  output logic [31:0] rdMr,
  output logic [31:0] rdTr,
  output logic [31:0] oldMr
);

  logic [31:0] mrQ [N];
  logic [31:0] trQ [N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        mrQ[i] <= '0;
        trQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wrMr && wrIdx == TLB_IDX_W'(i)) mrQ[i] <= wrData;
        if (wrTr && wrIdx == TLB_IDX_W'(i)) trQ[i] <= wrData;
      end
    end
  end

  always_comb begin
    rdMr = '0;
    rdTr = '0;
    oldMr = '0;
    for (int i = 0; i < N; i++) begin
      if (rdIdx == TLB_IDX_W'(i)) begin
        rdMr = mrQ[i];
        rdTr = trQ[i];
      end
      if (wrIdx == TLB_IDX_W'(i)) oldMr = mrQ[i];
    end
  end

endmodule

// File: rtl/spr_ctrl.sv
module spr_ctrl
  import spr_pkg::*;
#(
  parameter int N = 64
) (
  input  logic wrEn,
  input  logic [31:0] wrAddr,
  input  logic [31:0] wrData,
  input  logic [31:0] rdAddr,
  input  logic [31:0] srQ,
  output sprWrStrobe_t strobe,
  output sprTarget_t rdTarget,
  output logic flushAll
);

  function automatic sprTarget_t decode(input logic [31:0] a);
    sprTarget_t t;
    logic [4:0] grp;
    logic [10:0] num;
    t = '{sel: SEL_PREV, side: 1'b0, idx: '0};
    grp = a[15:11];
    num = a[10:0];
    if (a[31:16] == 16'h0) begin
      if (grp == 5'd0) begin
        case (num)
          11'd0:  t.sel = SEL_VR;
          11'd1:  t.sel = SEL_UPR;
          11'd2:  t.sel = SEL_CPUCFG;
          11'd3:  t.sel = SEL_DMMUCFG;
          11'd4:  t.sel = SEL_IMMUCFG;
          11'd17: t.sel = SEL_SR;
          11'd32: t.sel = SEL_EPCR;
          11'd48: t.sel = SEL_EEAR;
          11'd64: t.sel = SEL_ESR;
          default: t.sel = SEL_PREV;
        endcase
      end else if (grp == 5'd1 || grp == 5'd2) begin
        t.side = (grp == 5'd2);
        if (num >= 11'd512 && num < 11'(512 + N)) begin
          t.sel = SEL_MR;
          t.idx = TLB_IDX_W'(num - 11'd512);
        end else if (num >= 11'd640 && num < 11'(640 + N)) begin
          t.sel = SEL_TR;
          t.idx = TLB_IDX_W'(num - 11'd640);
        end
      end else if (grp == 5'd5) begin
        if (num == 11'd1) t.sel = SEL_MACLO;
        else if (num == 11'd2) t.sel = SEL_MACHI;
      end
    end
    return t;
  endfunction

  sprTarget_t wrTarget;

  always_comb begin
    wrTarget = decode(wrAddr);
    rdTarget = decode(rdAddr);
    strobe = '0;
    strobe.idx = wrTarget.idx;
    if (wrEn) begin
      case (wrTarget.sel)
        SEL_SR:    strobe.sr = 1'b1;
        SEL_EPCR:  strobe.epcr = 1'b1;
        SEL_EEAR:  strobe.eear = 1'b1;
        SEL_ESR:   strobe.esr = 1'b1;
        SEL_MACLO: strobe.macLo = 1'b1;
        SEL_MACHI: strobe.macHi = 1'b1;
        SEL_MR:    strobe.mr[wrTarget.side] = 1'b1;
        SEL_TR:    strobe.tr[wrTarget.side] = 1'b1;
        default:   ;
      endcase
    end
    flushAll = strobe.sr && (((wrData ^ srQ) & SR_MODE_MASK) != 32'h0);
  end

endmodule

// File: rtl/spr_datapath.sv
module spr_datapath
  import spr_pkg::*;
#(
  parameter int N = 64,
  parameter int PAGE_BITS = 13,
  parameter logic [31:0] VERSION = 32'h1200_0001,
  parameter logic [31:0] UNIT_PRESENT = 32'h0000_0619,
  parameter logic [31:0] CPU_CFG = 32'h0000_0020
) (
  input  logic clk,
  input  logic rstN,
  input  sprWrStrobe_t strobe,
  input  logic [31:0] wrData,
  input  sprTarget_t rdTarget,
  input  logic [31:0] rdPrev,
  output logic [31:0] rdData,
  output logic [31:0] srQ,
  output logic [31:0] flushPageAddr
);

  localparam logic [31:0] MMU_CFG = 32'($clog2(N)) << 2;
  localparam logic [31:0] PAGE_MASK = ~((32'h1 << PAGE_BITS) - 32'h1);

  logic [31:0] epcrQ, eearQ, esrQ;
  logic [63:0] macQ;
  logic [31:0] bankMr [2];
  logic [31:0] bankTr [2];
  logic [31:0] bankOld [2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srQ <= SR_RESET;
      epcrQ <= '0;
      eearQ <= '0;
      esrQ <= '0;
      macQ <= '0;
    end else begin
      if (strobe.sr) srQ <= wrData;
      if (strobe.epcr) epcrQ <= wrData;
      if (strobe.eear) eearQ <= wrData;
      if (strobe.esr) esrQ <= wrData;
      if (strobe.macLo) macQ[31:0] <= wrData;
      if (strobe.macHi) macQ[63:32] <= wrData;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_bank
    spr_tlb_bank #(.N(N)) u_bank (
      .clk(clk),
      .rstN(rstN),
      .wrMr(strobe.mr[s]),
      .wrTr(strobe.tr[s]),
      .wrIdx(strobe.idx),
      .wrData(wrData),
      .rdIdx(rdTarget.idx),
      .rdMr(bankMr[s]),
      .rdTr(bankTr[s]),
      .oldMr(bankOld[s])
    );
  end

  assign flushPageAddr = (strobe.mr[1] ? bankOld[1] : bankOld[0]) & PAGE_MASK;

  always_comb begin
    case (rdTarget.sel)
      SEL_VR:      rdData = VERSION;
      SEL_UPR:     rdData = UNIT_PRESENT;
      SEL_CPUCFG:  rdData = CPU_CFG;
      SEL_DMMUCFG: rdData = MMU_CFG;
      SEL_IMMUCFG: rdData = MMU_CFG;
      SEL_SR:      rdData = srQ;
      SEL_EPCR:    rdData = epcrQ;
      SEL_EEAR:    rdData = eearQ;
      SEL_ESR:     rdData = esrQ;
      SEL_MACLO:   rdData = macQ[31:0];
      SEL_MACHI:   rdData = macQ[63:32];
      SEL_MR:      rdData = bankMr[rdTarget.side];
      SEL_TR:      rdData = bankTr[rdTarget.side];
      default:     rdData = rdPrev;
    endcase
  end

endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
  import spr_pkg::*;
#(
  parameter int N = 64,
  parameter int PAGE_BITS = 13,
  parameter logic [31:0] VERSION = 32'h1200_0001,
  parameter logic [31:0] UNIT_PRESENT = 32'h0000_0619,
  parameter logic [31:0] CPU_CFG = 32'h0000_0020
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [31:0] wrBase,
  input  logic [15:0] wrImm,
  input  logic [31:0] wrData,
  input  logic [31:0] rdBase,
  input  logic [15:0] rdImm,
  input  logic [31:0] rdPrev,
  output logic [31:0] rdData,
  output logic flushAll,
  output logic flushPage,
  output logic flushPageInstr,
  output logic [31:0] flushPageAddr
);

  logic [31:0] wrAddr, rdAddr, srQ;
  sprWrStrobe_t strobe;
  sprTarget_t rdTarget;

  assign wrAddr = wrBase | {16'h0, wrImm};
  assign rdAddr = rdBase | {16'h0, rdImm};

  spr_ctrl #(.N(N)) u_ctrl (
    .wrEn(wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .srQ(srQ),
    .strobe(strobe),
    .rdTarget(rdTarget),
    .flushAll(flushAll)
  );

  spr_datapath #(
    .N(N), .PAGE_BITS(PAGE_BITS), .VERSION(VERSION),
    .UNIT_PRESENT(UNIT_PRESENT), .CPU_CFG(CPU_CFG)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .wrData(wrData),
    .rdTarget(rdTarget),
    .rdPrev(rdPrev),
    .rdData(rdData),
    .srQ(srQ),
    .flushPageAddr(flushPageAddr)
  );

  assign flushPage = |strobe.mr;
  assign flushPageInstr = strobe.mr[1];

endmodule

// File: rtl/spr_access_checker.sv
module spr_access_checker #(
  parameter int PAGE_BITS = 13
) (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic [31:0] rdBase,
  input logic [15:0] rdImm,
  input logic [31:0] rdPrev,
  input logic [31:0] rdData,
  input logic flushAll,
  input logic flushPage,
  input logic [31:0] flushPageAddr
);

  assert_full_flush_on_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |-> (wrEn && !flushPage));

  assert_page_flush_on_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    flushPage |-> (wrEn && !flushAll));

  assert_page_addr_aligned_R5: assert property (@(posedge clk) disable iff (!rstN)
    flushPage |-> (flushPageAddr[PAGE_BITS-1:0] == '0));

  assert_wide_base_returns_prev_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rdBase[31:16] != 16'h0) |-> (rdData == rdPrev));

  assert_read_holds_without_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn ##1 ($stable(rdBase) && $stable(rdImm) && $stable(rdPrev))) |-> $stable(rdData));

endmodule

bind spr_access_unit spr_access_checker #(.PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .wrEn(wrEn),
  .rdBase(rdBase),
  .rdImm(rdImm),
  .rdPrev(rdPrev),
  .rdData(rdData),
  .flushAll(flushAll),
  .flushPage(flushPage),
  .flushPageAddr(flushPageAddr)
);

// File: tb/test_spr_access_unit.sv
module test_spr_access_unit;

  localparam int CLK_PERIOD = 10;
  localparam int N = 64;
  localparam int K_NONE = 0, K_CONST = 1, K_SR = 2, K_EPCR = 3, K_EEAR = 4,
                 K_ESR = 5, K_MACLO = 6, K_MACHI = 7, K_MR = 8, K_TR = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrBase = '0, wrData = '0, rdBase = '0, rdPrev = '0;
  logic [15:0] wrImm = '0, rdImm = '0;
  logic [31:0] rdData, flushPageAddr;
  logic flushAll, flushPage, flushPageInstr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mSr, mEpcr, mEear, mEsr;
  logic [63:0] mMac;
  logic [31:0] mMr [2][N];
  logic [31:0] mTr [2][N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  spr_access_unit i_spr_access_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBase(wrBase), .wrImm(wrImm),
    .wrData(wrData), .rdBase(rdBase), .rdImm(rdImm), .rdPrev(rdPrev),
    .rdData(rdData), .flushAll(flushAll), .flushPage(flushPage),
    .flushPageInstr(flushPageInstr), .flushPageAddr(flushPageAddr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void bDecode(input logic [31:0] a, output int kind, output int side,
                                  output int idx, output logic [31:0] cval);
    int grp, num;
    kind = K_NONE; side = 0; idx = 0; cval = '0;
    grp = int'(a[15:11]);
    num = int'(a[10:0]);
    if (a[31:16] != 16'h0) return;
    if (grp == 0) begin
      kind = K_CONST;
      case (num)
        0: cval = 32'h1200_0001;
        1: cval = 32'h0000_0619;
        2: cval = 32'h0000_0020;
        3, 4: cval = 32'd6 << 2;
        17: kind = K_SR;
        32: kind = K_EPCR;
        48: kind = K_EEAR;
        64: kind = K_ESR;
        default: kind = K_NONE;
      endcase
    end else if (grp == 1 || grp == 2) begin
      side = grp - 1;
      if (num >= 512 && num < 512 + N) begin kind = K_MR; idx = num - 512; end
      else if (num >= 640 && num < 640 + N) begin kind = K_TR; idx = num - 640; end
    end else if (grp == 5) begin
      if (num == 1) kind = K_MACLO;
      else if (num == 2) kind = K_MACHI;
    end
  endfunction

  function automatic logic [31:0] expRead(input logic [31:0] a, input logic [31:0] prev, output string tag);
    int kind, side, idx;
    logic [31:0] cval;
    bDecode(a, kind, side, idx, cval);
    case (kind)
      K_CONST: begin tag = "R2"; return cval; end
      K_SR:    begin tag = "R3"; return mSr; end
      K_EPCR:  begin tag = "R3"; return mEpcr; end
      K_EEAR:  begin tag = "R3"; return mEear; end
      K_ESR:   begin tag = "R3"; return mEsr; end
      K_MACLO: begin tag = "R7"; return mMac[31:0]; end
      K_MACHI: begin tag = "R7"; return mMac[63:32]; end
      K_MR:    begin tag = "R6"; return mMr[side][idx]; end
      K_TR:    begin tag = "R6"; return mTr[side][idx]; end
      default: begin tag = "R8"; return prev; end
    endcase
  endfunction

  function automatic logic [47:0] splitAddr(input logic [31:0] a);
    logic [31:0] m;
    logic [15:0] imm;
    m = $urandom;
    imm = (a[15:0] & ~m[15:0]) | (a[15:0] & 16'($urandom));
    return {a & m, imm};
  endfunction

  task automatic runCycle(input bit we, input logic [31:0] wBase, input logic [15:0] wImm,
                          input logic [31:0] wD, input logic [31:0] rB, input logic [15:0] rI,
                          input logic [31:0] rP, input string tagOverride);
    logic [31:0] wa, expR, expPage;
    string tag;
    int kind, side, idx;
    logic [31:0] cval;
    bit expAll, expPg;
    @(negedge clk);
    wrEn = we; wrBase = wBase; wrImm = wImm; wrData = wD;
    rdBase = rB; rdImm = rI; rdPrev = rP;
    #1;
    expR = expRead(rB | {16'h0, rI}, rP, tag);
    if (tagOverride != "") tag = tagOverride;
    check(rdData == expR, tag, rdData, expR);
    wa = wBase | {16'h0, wImm};
    bDecode(wa, kind, side, idx, cval);
    expAll = we && kind == K_SR && (((wD ^ mSr) & 32'h61) != 0);
    expPg = we && kind == K_MR;
    check(flushAll == expAll, (tagOverride != "") ? tagOverride : "R4", 32'(flushAll), 32'(expAll));
    check(flushPage == expPg, (tagOverride != "") ? tagOverride : "R5", 32'(flushPage), 32'(expPg));
    if (expPg) begin
      expPage = mMr[side][idx] & ~32'h1FFF;
      check(flushPageAddr == expPage, "R5", flushPageAddr, expPage);
      check(flushPageInstr == (side == 1), "R5", 32'(flushPageInstr), 32'(side));
    end
    if (we) begin
      case (kind)
        K_SR:    mSr = wD;
        K_EPCR:  mEpcr = wD;
        K_EEAR:  mEear = wD;
        K_ESR:   mEsr = wD;
        K_MACLO: mMac[31:0] = wD;
        K_MACHI: mMac[63:32] = wD;
        K_MR:    mMr[side][idx] = wD;
        K_TR:    mTr[side][idx] = wD;
        default: ;
      endcase
    end
  endtask

  task automatic simpleCycle(input bit we, input logic [31:0] wa, input logic [31:0] wD,
                             input logic [31:0] ra, input logic [31:0] rP, input string tag);
    logic [47:0] ws, rs;
    ws = splitAddr(wa);
    rs = splitAddr(ra);
    runCycle(we, ws[47:16], ws[15:0], wD, rs[47:16], rs[15:0], rP, tag);
  endtask

  function automatic logic [31:0] pickAddr();
    int g;
    g = int'($urandom_range(1, 2));
    case ($urandom_range(0, 9))
      0: begin
        int regs [11] = '{0, 1, 2, 3, 4, 16, 17, 18, 32, 48, 64};
        return 32'(regs[$urandom_range(0, 10)]);
      end
      1, 2: return 32'((g << 11) | (512 + int'($urandom_range(0, N - 1))));
      3: return 32'((g << 11) | (640 + int'($urandom_range(0, N - 1))));
      4: return 32'((g << 11) | (512 + int'($urandom_range(0, 1023))));
      5: return 32'((5 << 11) | int'($urandom_range(0, 3)));
      6: return 32'd17;
      7: return {16'h0, 16'($urandom)};
      8: return {16'($urandom_range(1, 3)), 16'd32};
      default: return 32'(16 * int'($urandom_range(2, 4)));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    mSr = 32'h1; mEpcr = '0; mEear = '0; mEsr = '0; mMac = '0;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < N; i++) begin mMr[s][i] = '0; mTr[s][i] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R10: reset values
    simpleCycle(0, 0, 0, 32'd17, 32'hDEAD_0000, "R10");
    simpleCycle(0, 0, 0, 32'd48, 32'hDEAD_0001, "R10");
    simpleCycle(0, 0, 0, 32'((5 << 11) | 2), 32'hDEAD_0002, "R10");
    simpleCycle(0, 0, 0, 32'((2 << 11) | 640 + N - 1), 32'hDEAD_0003, "R10");

    // R1: OR combine (sum would select register 64)
    runCycle(1, 32'h20, 16'h20, 32'hAAAA_0001, 32'h20, 16'h20, 32'h1, "R1");
    runCycle(0, 0, 0, 0, 32'h0, 16'h20, 32'h2, "R1");
    runCycle(0, 0, 0, 0, 32'h0, 16'h40, 32'h3, "R1");
    runCycle(1, 32'h0001_0030, 16'h0, 32'h5555_5555, 32'h0001_0000, 16'h30, 32'h4, "R1");
    runCycle(0, 0, 0, 0, 32'h30, 16'h0, 32'h5, "R1");

    // R9: same-cycle read sees the old value, new value next cycle
    simpleCycle(1, 32'd48, 32'h1357_9BDF, 32'd48, 32'h6, "R9");
    simpleCycle(0, 0, 0, 32'd48, 32'h7, "R9");

    // R4: status writes with and without mode change
    simpleCycle(1, 32'd17, 32'h0000_8001, 32'd17, 32'h8, "R4");
    simpleCycle(1, 32'd17, 32'h0000_8021, 32'd17, 32'h9, "R4");
    simpleCycle(1, 32'd17, 32'h0000_8020, 32'd17, 32'hA, "R4");

    // R5: match write flushes old page
    simpleCycle(1, 32'((1 << 11) | 515), 32'h1234_5678, 32'd0, 32'hB, "R5");
    simpleCycle(1, 32'((1 << 11) | 515), 32'h0BAD_F00D, 32'((1 << 11) | 515), 32'hC, "R5");
    simpleCycle(1, 32'((2 << 11) | 512 + N - 1), 32'hFFFF_FFFF, 32'd0, 32'hD, "R5");
    simpleCycle(1, 32'((2 << 11) | 512 + N - 1), 32'h1, 32'((2 << 11) | 512 + N - 1), 32'hE, "R5");

    // R2: writes to configuration registers change nothing
    simpleCycle(1, 32'd0, 32'hFFFF_FFFF, 32'd0, 32'hF, "R2");
    simpleCycle(1, 32'd3, 32'h0, 32'd3, 32'h10, "R2");

    // R7: halves independent
    simpleCycle(1, 32'((5 << 11) | 1), 32'hCAFE_0001, 32'((5 << 11) | 2), 32'h11, "R7");
    simpleCycle(1, 32'((5 << 11) | 2), 32'hBEEF_0002, 32'((5 << 11) | 1), 32'h12, "R7");
    simpleCycle(0, 0, 0, 32'((5 << 11) | 2), 32'h13, "R7");

    // R8: unbacked ranges, including the way 1..3 area and the gap above N
    simpleCycle(1, 32'((1 << 11) | 768), 32'h7777_7777, 32'((1 << 11) | 768), 32'h14, "R8");
    simpleCycle(1, 32'((1 << 11) | 512 + N), 32'h7777_7777, 32'((1 << 11) | 512 + N), 32'h15, "R8");
    simpleCycle(1, 32'd16, 32'h7777_7777, 32'd18, 32'h16, "R8");

    // R6: translate writes store without flush
    simpleCycle(1, 32'((2 << 11) | 640), 32'h2468_ACE0, 32'((2 << 11) | 640), 32'h17, "R6");
    simpleCycle(0, 0, 0, 32'((2 << 11) | 640), 32'h18, "R6");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] wa, wd;
      wa = pickAddr();
      wd = $urandom;
      if (wa == 32'd17 && $urandom_range(0, 1) == 1) wd = mSr ^ (wd & ~32'h61);
      simpleCycle(($urandom_range(0, 3) != 0), wa, wd, pickAddr(), $urandom, "");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule